// File: doc/BRIEF.md
# PPS Period Monitor

This block observes an external pulse-per-second input on a fast system clock. It measures the number of system cycles between successive selected edges of that input and holds the latest measurement. It also inverts a toggle bit on each detected pulse and raises a stable flag when the measured period agrees with a period that software has programmed. Software uses it to qualify a timing reference before trusting it.

Access is through a two-word register interface on a separate bus clock. The status word is read-only. The control word selects the edge and holds the expected period. Status crosses into the bus domain as a coherent snapshot through a toggle handshake. Control crosses into the system domain the same way.

Top module: `pps_monitor`

## Requirements
- R1: Word 0 (address 0) is status. Bit 31 is the toggle, bit 30 is the stable flag, and bits 29:0 hold the captured count, zero-extended from CNT_W bits. After reset word 0 reads 0.
- R2: Word 1 (address 1) is control. Bit 31 is the edge select, where 0 means the rising edge and 1 means the falling edge. Bits 30:0 are the expected period. A write to word 1 reads back unchanged.
- R3: After reset the edge select is 0 and the expected period is EXP_RESET, which defaults to 200,000,000.
- R4: The captured count equals the exact number of system cycles between the two most recent selected edges, in both edge modes.
- R5: The toggle bit inverts on every detected pulse and only then, so two reads taken around one pulse differ in bit 31.
- R6: The stable flag reads 1 after a pulse whose measured period equalled the expected period, as long as the captured count still equals the expected period.
- R7: The stable flag is 0 whenever the captured count differs from the expected period. This includes the first pulse with a mismatching period and a change of the expected period.
- R8: The period counter stops at 2^CNT_W-1 when no pulse arrives. It restarts on the following pulse, so the next period is again measured exactly.
- R9: Writes to word 0 change neither word. Read data appears one bus cycle after the read strobe and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock that samples the pulse input and runs the counter |
| bus_clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| pps_i | input | 1 | External pulse-per-second input, asynchronous |
| bus_addr_i | input | 1 | Word select: 0 status, 1 control |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |

## Verification
Two things can fall in the same cycle: counter saturation and pulse capture. The bench provokes this by leaving a gap between pulses longer than the counter range, with the counter width reduced to 8 bits. The capture must then report the saturated value 255 while the counter restarts in that same cycle. A following 40-cycle pulse must read exactly 40, which shows the restart was not lost to the saturation hold.

// File: rtl/pps_mon_pkg.sv
`timescale 1ns/1ps
package pps_mon_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_FLD = 30;
  localparam int EXP_W   = 31;

  typedef struct packed {
    logic               toggle;
    logic               stable;
    logic [CNT_FLD-1:0] count;
  } status_t;

  typedef struct packed {
    logic             edge_fall;
    logic [EXP_W-1:0] expected;
  } ctrl_t;
endpackage

// File: rtl/pps_edge_det.sv
`timescale 1ns/1ps
module pps_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_N:0] sh_q;
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], pps_i};
  end

  assign cur    = sh_q[SYNC_N-1];
  assign prev   = sh_q[SYNC_N];
  assign edge_o = fall_sel_i ? (~cur & prev) : (cur & ~prev);
endmodule

// File: rtl/pps_period_cnt.sv
`timescale 1ns/1ps
module pps_period_cnt #(
  parameter int CNT_W = 30,
  parameter int EXP_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [EXP_W-1:0] expected_i,
  output logic [CNT_W-1:0] count_o,
  output logic             toggle_o,
  output logic             stable_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cap_q;
  logic tog_q, seen_q;
  logic match_now, match_cap;

  assign match_now = (expected_i == EXP_W'(cnt_q));
  assign match_cap = (expected_i == EXP_W'(cap_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      tog_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q  <= CNT_W'(1);
      cap_q  <= cnt_q;
      tog_q  <= ~tog_q;
      seen_q <= match_now;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o  = cap_q;
  assign toggle_o = tog_q;
  // flag drops at once if expected moves away from the held count
  assign stable_o = seen_q & match_cap;
endmodule

// File: rtl/pps_xfer.sv
`timescale 1ns/1ps
module pps_xfer #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_data_i,
  output logic [W-1:0] dst_data_o
);
  logic         req_q;
  logic [1:0]   ack_s;
  logic [W-1:0] hold_q;
  logic [2:0]   req_s;
  logic [W-1:0] dst_q;

  // source: reload hold only once previous word was taken
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ack_s  <= '0;
      hold_q <= RST_VAL;
    end else begin
      ack_s <= {ack_s[0], req_s[2]};
      if (ack_s[1] == req_q) begin
        hold_q <= src_data_i;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s <= '0;
      dst_q <= RST_VAL;
    end else begin
      req_s <= {req_s[1:0], req_q};
      if (req_s[1] != req_s[2]) dst_q <= hold_q;
    end
  end

  assign dst_data_o = dst_q;
endmodule

// File: rtl/pps_monitor.sv
`timescale 1ns/1ps
module pps_monitor
  import pps_mon_pkg::*;
#(
  parameter int          CNT_W     = 30,
  parameter int unsigned EXP_RESET = 200_000_000,
  parameter int          SYNC_N    = 2
) (
  input  logic             sys_clk_i,
  input  logic             bus_clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic             bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  output logic [REG_W-1:0] bus_rdata_o
);
  localparam ctrl_t CTRL_RST = '{edge_fall: 1'b0, expected: EXP_W'(EXP_RESET)};

  ctrl_t            ctrl_bus_q, ctrl_sys;
  status_t          status_sys, status_bus;
  logic             edge_pulse;
  logic [CNT_W-1:0] count;
  logic             toggle_s, stable_s;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_bus_q <= CTRL_RST;
    else if (bus_we_i && bus_addr_i) ctrl_bus_q <= ctrl_t'(bus_wdata_i);
  end

  pps_xfer #(.W(REG_W), .RST_VAL(CTRL_RST)) u_ctrl_xfer (
    .src_clk_i (bus_clk_i),
    .dst_clk_i (sys_clk_i),
    .rst_ni    (rst_ni),
    .src_data_i(ctrl_bus_q),
    .dst_data_o(ctrl_sys)
  );

  pps_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i     (sys_clk_i),
    .rst_ni    (rst_ni),
    .pps_i     (pps_i),
    .fall_sel_i(ctrl_sys.edge_fall),
    .edge_o    (edge_pulse)
  );

  pps_period_cnt #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_cnt (
    .clk_i     (sys_clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_pulse),
    .expected_i(ctrl_sys.expected),
    .count_o   (count),
    .toggle_o  (toggle_s),
    .stable_o  (stable_s)
  );

  assign status_sys = '{toggle: toggle_s, stable: stable_s, count: CNT_FLD'(count)};

  pps_xfer #(.W(REG_W), .RST_VAL('0)) u_stat_xfer (
    .src_clk_i (sys_clk_i),
    .dst_clk_i (bus_clk_i),
    .rst_ni    (rst_ni),
    .src_data_i(status_sys),
    .dst_data_o(status_bus)
  );

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= bus_addr_i ? REG_W'(ctrl_bus_q) : REG_W'(status_bus);
  end
endmodule

// File: rtl/pps_monitor_chk.sv
`timescale 1ns/1ps
module pps_monitor_chk #(
  parameter int CNT_W = 30
) (
  input logic             sys_clk_i,
  input logic             bus_clk_i,
  input logic             rst_ni,
  input logic             edge_i,
  input logic [CNT_W-1:0] count_i,
  input logic             toggle_i,
  input logic             stable_i,
  input logic [30:0]      expected_i,
  input logic [31:0]      ctrl_bus_i,
  input logic             addr_i,
  input logic             we_i,
  input logic             re_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_i
);
  a_r5_toggle_flip: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    edge_i |=> (toggle_i != $past(toggle_i)));
  a_r5_toggle_hold: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(toggle_i));
  a_r4_count_hold: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(count_i));
  a_r7_stable_match: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    stable_i |-> (expected_i == 31'(count_i)));
  a_r9_rdata_hold: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i));
  a_r9_word0_ro: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> $stable(ctrl_bus_i));
  a_r2_ctrl_write: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> (ctrl_bus_i == $past(wdata_i)));
endmodule

bind pps_monitor pps_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .sys_clk_i (sys_clk_i),
  .bus_clk_i (bus_clk_i),
  .rst_ni    (rst_ni),
  .edge_i    (edge_pulse),
  .count_i   (count),
  .toggle_i  (toggle_s),
  .stable_i  (stable_s),
  .expected_i(ctrl_sys.expected),
  .ctrl_bus_i(ctrl_bus_q),
  .addr_i    (bus_addr_i),
  .we_i      (bus_we_i),
  .re_i      (bus_re_i),
  .wdata_i   (bus_wdata_i),
  .rdata_i   (bus_rdata_o)
);

// File: tb/pps_monitor_tb_top.sv
`timescale 1ns/1ps
module pps_monitor_tb_top;
  localparam int CNT_W = 8;

  logic sys_clk = 1'b0, bus_clk = 1'b0, rst_n = 1'b0;
  logic pps = 1'b0;
  logic addr = 1'b0, we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;

  int errors = 0, checks = 0, n_pulses = 0;
  bit done = 1'b0;

  always #5 sys_clk = ~sys_clk;
  always #7 bus_clk = ~bus_clk;

  pps_monitor #(.CNT_W(CNT_W)) dut_i (
    .sys_clk_i(sys_clk), .bus_clk_i(bus_clk), .rst_ni(rst_n), .pps_i(pps),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
    .bus_rdata_o(rdata)
  );

  typedef struct packed {
    logic [15:0] period;
    logic        fall;
    logic [30:0] expv;
    logic        stab;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{16'd40, 1'b0, 31'd40,  1'b1},
    '{16'd40, 1'b0, 31'd41,  1'b0},
    '{16'd57, 1'b1, 31'd57,  1'b1},
    '{16'd33, 1'b1, 31'd100, 1'b0},
    '{16'd64, 1'b0, 31'd64,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d);
    @(negedge bus_clk); addr = a; re = 1'b1;
    @(negedge bus_clk); re = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge bus_clk); addr = a; wdata = d; we = 1'b1;
    @(negedge bus_clk); we = 1'b0;
    repeat (20) @(negedge sys_clk);
  endtask

  task automatic pulses(input int n, input int period);
    for (int k = 0; k < n; k++) begin
      @(negedge sys_clk); pps = 1'b1; n_pulses++;
      repeat (3) @(negedge sys_clk);
      pps = 1'b0;
      repeat (period - 4) @(negedge sys_clk);
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge sys_clk);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, w1;
    repeat (4) @(negedge sys_clk);
    rst_n = 1'b1;
    settle();

    // R1, R3: reset state
    bus_rd(1'b0, d); chk("R1 reset status", d, 32'h0);
    bus_rd(1'b1, d); chk("R3 reset ctrl", d, {1'b0, 31'd200_000_000});

    for (int i = 0; i < 5; i++) begin
      bus_wr(1'b1, {VEC[i].fall, VEC[i].expv});
      bus_rd(1'b1, d); chk("R2 ctrl readback", d, {VEC[i].fall, VEC[i].expv});
      pulses(3, int'(VEC[i].period));
      settle();
      bus_rd(1'b0, d);
      chk("R4 count", {2'b0, d[29:0]}, {16'b0, VEC[i].period});
      chk(VEC[i].stab ? "R6 stable" : "R7 stable low", {31'b0, d[30]}, {31'b0, VEC[i].stab});
      chk("R5 toggle parity", {31'b0, d[31]}, {31'b0, n_pulses[0]});
    end

    // R7: expected changes away from captured 64
    bus_wr(1'b1, {1'b0, 31'd65});
    settle();
    bus_rd(1'b0, d);
    chk("R7 expected change drops stable", {31'b0, d[30]}, 32'h0);
    chk("R7 count kept", {2'b0, d[29:0]}, 32'd64);

    // R6/R7: match, then first mismatching pulse clears
    bus_wr(1'b1, {1'b0, 31'd64});
    pulses(3, 64);
    pulses(2, 50);
    settle();
    bus_rd(1'b0, d);
    chk("R7 first mismatch clears", {31'b0, d[30]}, 32'h0);
    chk("R4 count 50", {2'b0, d[29:0]}, 32'd50);

    // R5: one pulse between two reads
    bus_rd(1'b0, d);
    pulses(1, 40);
    settle();
    bus_rd(1'b0, d2);
    chk("R5 toggle inverts", {31'b0, d2[31]}, {31'b0, ~d[31]});

    // R9: word 0 is read-only
    bus_rd(1'b1, w1);
    bus_rd(1'b0, d);
    bus_wr(1'b0, 32'hFFFF_FFFF);
    bus_rd(1'b0, d2); chk("R9 status untouched", d2, d);
    bus_rd(1'b1, d2); chk("R9 ctrl untouched", d2, w1);

    // R8: saturation coincides with capture, then exact restart
    pulses(2, 400);
    settle();
    bus_rd(1'b0, d);
    chk("R8 saturated count", {2'b0, d[29:0]}, 32'd255);
    pulses(2, 40);
    settle();
    bus_rd(1'b0, d);
    chk("R8 restart exact", {2'b0, d[29:0]}, 32'd40);

    // R9: read latency and hold
    @(negedge bus_clk); addr = 1'b1; re = 1'b1;
    @(negedge bus_clk); re = 1'b0; addr = 1'b0;
    chk("R9 one-cycle read", rdata, w1);
    repeat (3) @(negedge bus_clk);
    chk("R9 rdata holds", rdata, w1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule